// File: doc/BRIEF.md
# Edge-Gated BCD Period Counter

This block measures how long one cycle of a slow signal lasts, in ticks of a fast reference clock. A start pulse clears the result and arms the block. The measured signal is resynchronised into the reference clock domain, and the block watches it for a falling edge. The first falling edge after arming opens a gate, and each reference cycle spent with the gate open adds one to a decimal result. The next falling edge closes the gate. The result then stays frozen until the next start. With a 1 µs reference tick, the result reads directly as the period in microseconds.

The result is a packed BCD counter whose digit count is a parameter (five digits by default). The counter stops at its all-nines value and raises a sticky overflow flag. A single-cycle done pulse tells downstream logic that the result is ready to capture. A busy output covers the span from arming to the closing edge.

A second mode measures frequency. It is sampled while start is high. In this mode the gate is one window of fixed length, derived from a reference-clock divider that is set to one second by default. During that window the counter counts synchronised falling edges of the measured signal.

Top module: `period_gate_meter`

## Requirements
- R1: While `start` is high, every BCD digit, `gate` and `overflow` are cleared on each clock, and no measured edge opens the gate.
- R2: In period mode, after `start` returns low, the first synchronised falling edge of `sig_in` raises `gate`. From then on the counter gains one in every reference cycle in which `gate` is high.
- R3: In period mode, the next synchronised falling edge of `sig_in` lowers `gate`, and counting stops.
- R4: Once `gate` has closed, `count_bcd` does not change, whatever `sig_in` does, until the next `start`.
- R5: `count_bcd` is packed 8421 BCD. Digit i sits at bits [4i+3:4i], so the units digit is in bits [3:0]. Every digit stays in 0..9.
- R6: For a steady periodic input whose period is P reference cycles, a period-mode measurement ends with `count_bcd` equal to P in decimal, provided P is at most the all-nines value.
- R7: If the count would step past the all-nines value while the gate is open, the count holds at all nines. `overflow` then rises and stays high until the next `start`.
- R8: `done` is high for exactly one cycle: the first cycle in which `gate` is low after a measurement closes.
- R9: `busy` is high from the cycle after `start` is first seen until `gate` closes. `gate` is never high without `busy`.
- R10: A `start` that arrives while a measurement is in progress clears the result and re-arms the block. The next measurement then completes normally.
- R11: In frequency mode (`freq_mode` = 1 while `start` is high), `gate` rises in the cycle after `start` falls and stays high for exactly WINDOW_TICKS cycles. The result equals the number of synchronised falling edges of `sig_in` seen in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; every tick is one unit of measurement |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear and arm the block; held high keeps it cleared |
| freq_mode | input | 1 | Mode select, sampled while start is high: 0 period, 1 frequency |
| sig_in | input | 1 | Measured signal, asynchronous to clk |
| count_bcd | output | 4*DIGITS | Packed BCD result, units digit in the lowest nibble |
| gate | output | 1 | High while the measurement window is open |
| busy | output | 1 | High from arming until the window closes |
| done | output | 1 | One-cycle pulse when a result becomes final |
| overflow | output | 1 | Sticky flag: the count saturated at all nines |

## Verification
The bench goes after the cases where counting is off by one cycle. If the closing edge's own cycle were left out, a square wave of known period would read one short. If the gate width in frequency mode were off by one, an edge that lands exactly at the window's end would be gained or lost. It drives a period longer than the counter can hold. A design that wrapped to zero, or that cleared overflow, would give a small value, or the flag would drop later. It also restarts the block mid-measurement and holds start high while the input toggles. A design that kept stale digits, or let an edge open the gate under start, would fail to read zero there and would report the aborted span. Because the input keeps toggling after the gate closes, a design that re-armed by itself would show a drifting result.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

    // Measurement sequencer states
    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_ARMED = 2'd1,
        MS_OPEN  = 2'd2,
        MS_HELD  = 2'd3
    } meas_state_e;

    localparam int unsigned NIBBLE_W = 4;
    localparam logic [NIBBLE_W-1:0] BCD_NINE = 4'd9;

endpackage

// File: rtl/pgm_sync_edge.sv
// Brings the measured signal into the reference domain and flags falling edges.
module pgm_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall_pulse
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.chain = {r_q.chain[STAGES-2:0], async_in};
        r_d.last  = r_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign fall_pulse = r_q.last & ~r_q.chain[STAGES-1];

endmodule

// File: rtl/pgm_bcd_chain.sv
// Cascaded decimal digits with saturation at all nines and a sticky overflow.
module pgm_bcd_chain
    import pgm_pkg::*;
#(
    parameter int unsigned DIGITS = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       inc,
    output logic [NIBBLE_W*DIGITS-1:0] value,
    output logic                       ovf
);
    logic [DIGITS-1:0] nine;
    logic [DIGITS-1:0] carry;
    logic              full;
    logic              ovf_d, ovf_q;

    assign full = &nine;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [NIBBLE_W-1:0] dig_d, dig_q;

        if (g == 0) begin : g_first
            assign carry[g] = inc & ~full;
        end else begin : g_next
            assign carry[g] = carry[g-1] & nine[g-1];
        end

        assign nine[g] = (dig_q == BCD_NINE);

        always_comb begin
            dig_d = dig_q;
            if (clr) begin
                dig_d = '0;
            end else if (carry[g]) begin
                dig_d = nine[g] ? '0 : dig_q + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dig_q <= '0;
            end else begin
                dig_q <= dig_d;
            end
        end

        assign value[NIBBLE_W*g +: NIBBLE_W] = dig_q;
    end

    always_comb begin
        ovf_d = ovf_q;
        if (clr) begin
            ovf_d = 1'b0;
        end else if (inc && full) begin
            ovf_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= ovf_d;
        end
    end

    assign ovf = ovf_q;

endmodule

// File: rtl/pgm_gate_fsm.sv
// Arms on start, opens and closes the window, and drives the count enable.
module pgm_gate_fsm
    import pgm_pkg::*;
#(
    parameter int unsigned WINDOW_TICKS = 125_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic freq_mode,
    input  logic fall,
    output logic gate,
    output logic busy,
    output logic done,
    output logic inc,
    output logic clr
);
    localparam int unsigned WIN_W = $clog2(WINDOW_TICKS + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_TICKS - 1);

    typedef struct packed {
        meas_state_e      state;
        logic             mode;
        logic [WIN_W-1:0] win;
        logic             done;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;
    logic      close;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        close    = 1'b0;
        inc      = 1'b0;
        if (start) begin
            r_d.state = MS_ARMED;
            r_d.mode  = freq_mode;
            r_d.win   = '0;
        end else begin
            unique case (r_q.state)
                MS_ARMED: begin
                    if (r_q.mode || fall) begin
                        r_d.state = MS_OPEN;
                    end
                end
                MS_OPEN: begin
                    inc   = r_q.mode ? fall : 1'b1;
                    close = r_q.mode ? (r_q.win == WIN_LAST) : fall;
                    if (close) begin
                        r_d.state = MS_HELD;
                        r_d.done  = 1'b1;
                    end else if (r_q.mode) begin
                        r_d.win = r_q.win + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: MS_IDLE, mode: 1'b0, win: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign gate = (r_q.state == MS_OPEN);
    assign busy = (r_q.state == MS_OPEN) || (r_q.state == MS_ARMED);
    assign done = r_q.done;
    assign clr  = start;

endmodule

// File: rtl/period_gate_meter.sv
module period_gate_meter #(
    parameter int unsigned DIGITS       = 5,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned WINDOW_TICKS = 125_000_000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  freq_mode,
    input  logic                  sig_in,
    output logic [4*DIGITS-1:0]   count_bcd,
    output logic                  gate,
    output logic                  busy,
    output logic                  done,
    output logic                  overflow
);
    logic fall;
    logic inc;
    logic clr;

    pgm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (sig_in),
        .fall_pulse (fall)
    );

    pgm_gate_fsm #(.WINDOW_TICKS(WINDOW_TICKS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .freq_mode (freq_mode),
        .fall      (fall),
        .gate      (gate),
        .busy      (busy),
        .done      (done),
        .inc       (inc),
        .clr       (clr)
    );

    pgm_bcd_chain #(.DIGITS(DIGITS)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (inc),
        .value (count_bcd),
        .ovf   (overflow)
    );

endmodule

// File: rtl/pgm_checker.sv
module pgm_checker #(
    parameter int unsigned DIGITS = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [4*DIGITS-1:0] count_bcd,
    input logic                gate,
    input logic                busy,
    input logic                done,
    input logic                overflow
);
    function automatic logic digits_ok(input logic [4*DIGITS-1:0] v);
        logic ok = 1'b1;
        for (int i = 0; i < int'(DIGITS); i++) begin
            if (v[4*i +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic all_nines(input logic [4*DIGITS-1:0] v);
        logic ok = 1'b1;
        for (int i = 0; i < int'(DIGITS); i++) begin
            if (v[4*i +: 4] != 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count_bcd == '0 && !gate && !overflow)); // R1
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !start) |=> $stable(count_bcd)); // R4
    AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        digits_ok(count_bcd)); // R5
    AST_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> all_nines(count_bcd)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !start) |=> overflow); // R7
    AST_DONE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!gate && $past(gate))); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_GATE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> busy); // R9

endmodule

bind period_gate_meter pgm_checker #(.DIGITS(DIGITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .count_bcd (count_bcd),
    .gate      (gate),
    .busy      (busy),
    .done      (done),
    .overflow  (overflow)
);

// File: tb/period_gate_meter_tb_top.sv
`timescale 1ns/1ps
module period_gate_meter_tb_top;
    localparam int DIG  = 2;
    localparam int WIN  = 64;
    localparam int MAXV = 99;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic freq_mode = 1'b0;
    logic sig_in = 1'b1;
    logic [4*DIG-1:0] count_bcd;
    logic gate, busy, done, overflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    period_gate_meter #(.DIGITS(DIG), .SYNC_STAGES(2), .WINDOW_TICKS(WIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .freq_mode(freq_mode),
        .sig_in(sig_in), .count_bcd(count_bcd), .gate(gate), .busy(busy),
        .done(done), .overflow(overflow)
    );

    function automatic logic [4*DIG-1:0] to_bcd(input int v);
        logic [4*DIG-1:0] r = '0;
        int x = v;
        for (int i = 0; i < DIG; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Square-wave stimulus on sig_in
    int gen_hi = 0;
    int gen_per = 0;
    int ph = 0;
    always @(negedge clk) begin
        if (gen_per > 0) begin
            sig_in = (ph < gen_hi);
            ph = (ph + 1) % gen_per;
        end
    end

    // Behavioural reference model
    int m_st, m_win, m_cnt;
    bit m_mode, m_ovf, m_done;
    bit samp[$];
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_win = 0; m_cnt = 0; m_mode = 0; m_ovf = 0; m_done = 0;
            samp = '{1'b1, 1'b1, 1'b1};
        end else begin
            bit f, step, shut;
            f = (samp[1] == 1'b0) && (samp[0] == 1'b1);
            samp.push_back(sig_in);
            void'(samp.pop_front());
            if (start) begin
                m_st = 1; m_mode = freq_mode; m_win = 0; m_cnt = 0; m_ovf = 0; m_done = 0;
            end else if (m_st == 1) begin
                m_done = 0;
                if (m_mode || f) m_st = 2;
            end else if (m_st == 2) begin
                step = m_mode ? f : 1'b1;
                shut = m_mode ? (m_win == WIN - 1) : f;
                if (step) begin
                    if (m_cnt == MAXV) m_ovf = 1; else m_cnt++;
                end
                m_done = shut;
                if (shut) m_st = 3;
                else if (m_mode) m_win++;
            end else begin
                m_done = 0;
            end
        end
    end

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R6 count",    int'(count_bcd), int'(to_bcd(m_cnt)));
            check("R2 gate",     int'(gate),      int'(m_st == 2));
            check("R9 busy",     int'(busy),      int'(m_st == 1 || m_st == 2));
            check("R8 done",     int'(done),      int'(m_done));
            check("R7 overflow", int'(overflow),  int'(m_ovf));
        end
    end

    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(input bit fm);
        @(negedge clk);
        freq_mode = fm;
        start = 1'b1;
        cycles(2);
        start = 1'b0;
    endtask

    task automatic set_wave(input int hi, input int per);
        @(negedge clk);
        gen_hi = hi; gen_per = per; ph = 0;
    endtask

    initial begin
        cycles(3);
        check("R1 reset count", int'(count_bcd), 0);
        check("R9 reset busy", int'(busy), 0);
        @(negedge clk); rst_n = 1'b1;
        cycles(2);

        // R1: start held high while the input toggles
        set_wave(3, 6);
        @(negedge clk); start = 1'b1;
        begin
            int bad = 0;
            cycles(1);
            for (int i = 0; i < 30; i++) begin
                if (count_bcd != '0 || gate) bad++;
                cycles(1);
            end
            check("R1 cleared under start", bad, 0);
        end
        start = 1'b0;

        // R2 R3 R6: symmetric period of 20
        set_wave(10, 20);
        arm(1'b0);
        begin
            int seen_gate = 0, seen_done = 0;
            for (int i = 0; i < 100; i++) begin
                if (gate) seen_gate++;
                if (done) seen_done++;
                cycles(1);
            end
            check("R2 gate opened for one period", seen_gate, 20);
            check("R8 single done pulse", seen_done, 1);
        end
        check("R6 period 20", int'(count_bcd), int'(to_bcd(20)));
        check("R3 gate closed", int'(gate), 0);
        cycles(100);
        check("R4 held after close", int'(count_bcd), int'(to_bcd(20)));

        // R5 R6: asymmetric period of 37
        set_wave(5, 37);
        arm(1'b0);
        cycles(150);
        check("R5 R6 period 37", int'(count_bcd), int'(8'h37));

        // R7: period longer than the counter range
        set_wave(75, 150);
        arm(1'b0);
        cycles(400);
        check("R7 saturated", int'(count_bcd), int'(8'h99));
        check("R7 overflow set", int'(overflow), 1);

        // R10: abort mid-measurement
        set_wave(30, 60);
        arm(1'b0);
        begin
            int lim = 0;
            while (!gate && lim < 200) begin cycles(1); lim++; end
        end
        cycles(10);
        start = 1'b1;
        cycles(1);
        check("R10 cleared by abort", int'(count_bcd), 0);
        check("R10 overflow cleared", int'(overflow), 0);
        cycles(1);
        start = 1'b0;
        cycles(250);
        check("R10 remeasure", int'(count_bcd), int'(to_bcd(60)));

        // R11: frequency window
        set_wave(4, 8);
        arm(1'b1);
        begin
            int w = 0;
            for (int i = 0; i < WIN + 20; i++) begin
                if (gate) w++;
                cycles(1);
            end
            check("R11 window width", w, WIN);
        end
        check("R11 edge count", int'(count_bcd), int'(to_bcd(WIN / 8)));
        check("R11 busy low after window", int'(busy), 0);

        cycles(5);
        finish_run();
    end

endmodule